// File: doc/BRIEF.md
# I2C Bus Monitor and Collision Detector

This block sits beside a clock-synchronous serial port that has an optional I2C behaviour. It watches the open-drain SCL and SDA lines and keeps a bus-busy flag: START sets it and STOP clears it. It also compares each transmitted data bit with the level actually seen on SDA. When the transmitter releases SDA high but the line reads low, another master has won the bus. That collision sets an arbitration-lost flag, which updates either on every bit or once per byte. If software allows it, the collision also requests that the transmit enable be cleared.

A small control register holds the mode bits. It also chooses what starts a transmission: a rising edge of the transfer clock or a pulse from an external timer underflow. With the I2C enable bit at 0, the port is a plain serial port and all bus monitoring is inactive. Shifting data and generating the baud rate are done elsewhere.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After synchronous reset, `ctl_q` reads 0x80, and `busy`, `arb_lost`, `coll_pulse`, `te_clr` and `tx_start` are all 0.
- R2: A write with `ctl_we` high is visible on `ctl_q` one clock later. The bit layout is: bit 0 I2C enable, bit 1 per-byte arbitration update, bit 2 auto-clear of transmit enable, bit 3 sample collisions on the RXD falling edge, bit 4 start transmission on a timer pulse. Bits 6:5 always read 0 and bit 7 always reads 1, whatever is written to them.
- R3: Both pins pass through a two-flop synchronizer. SDA falling while SCL is high (a START) sets `busy` on the third rising clock edge after the pin change, and not earlier.
- R4: SDA rising while SCL is high (a STOP) clears `busy`, with the same three-edge latency. SDA changes while SCL is low leave `busy` unchanged.
- R5: With the I2C enable bit at 0, `busy` stays 0. No collision is recognised, so `arb_lost`, `coll_pulse` and `te_clr` are not set.
- R6: With bit 3 at 0, the sampling point is a clock edge at which `xfer_clk` is 1 and was 0 on the previous edge. At that point, `tx_bit`=1 with synchronized SDA=0 is a collision. It raises `coll_pulse` for one cycle and, in per-bit mode, sets `arb_lost` on the same edge. `tx_bit`=0, or SDA high, is not a collision.
- R7: In per-byte mode, collisions are ORed over 8 sampling points. `arb_lost` changes only at the 8th sampling point, when it is set if any of the 8 collided. A START, or the I2C enable bit at 0, restarts the bit count.
- R8: With bit 3 at 1, the sampling point is a falling edge of `rxd` (1 on the previous edge, 0 now). Transfer-clock edges then sample nothing.
- R9: With the auto-clear bit at 1, each collision gives a one-cycle `te_clr` pulse on the same edge as `coll_pulse`. With the bit at 0, `te_clr` stays 0.
- R10: `arb_clr` high for one cycle clears `arb_lost` at the next edge. If a flag-setting collision occurs in that same cycle, the set wins and `arb_lost` stays 1.
- R11: `tx_start` is a one-cycle pulse one edge after the trigger. With bit 4 at 0 the trigger is a rising edge of `xfer_clk`; with bit 4 at 1 it is `timer_uf` high. The trigger that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wd | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register contents |
| scl_pin | input | 1 | Raw SCL line level |
| sda_pin | input | 1 | Raw SDA line level |
| tx_bit | input | 1 | Data bit the transmitter is currently driving |
| xfer_clk | input | 1 | Transfer clock, synchronous to clk |
| rxd | input | 1 | Receive data line, synchronous to clk |
| timer_uf | input | 1 | Timer underflow pulse |
| arb_clr | input | 1 | Software clear of the arbitration-lost flag |
| busy | output | 1 | Bus-busy flag |
| arb_lost | output | 1 | Arbitration-lost flag |
| coll_pulse | output | 1 | One-cycle pulse per detected collision |
| te_clr | output | 1 | Request to clear transmit enable |
| tx_start | output | 1 | Transmission start pulse |

## Verification
Each result has a fixed latency, counted in rising clock edges after its stimulus:
- `busy` reacts on the third edge after an SDA pin change (two synchronizer flops, then one registered edge detector).
- `coll_pulse`, `te_clr` and `arb_lost` settle on the sampling edge itself.
- `tx_start` and `ctl_q` appear one edge after their trigger or write.

The bench changes inputs just after a falling edge and reads outputs at a later falling edge, the exact number of edges later. For busy it checks both the edge before the change, where the old value must still hold, and the edge of the change. Before every sampling edge, SDA and `tx_bit` are held for several cycles, so the synchronized level is settled when it is compared.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int CTL_W = 8;
  localparam logic [CTL_W-1:0] CTL_RESET = 8'h80;

  typedef struct packed {
    logic       fixed_one;    // bit 7
    logic [1:0] rsvd;         // bits 6:5
    logic       timer_start;  // bit 4
    logic       rxd_sample;   // bit 3
    logic       auto_clr;     // bit 2
    logic       byte_mode;    // bit 1
    logic       i2c_en;       // bit 0
  } ctl_t;

  function automatic ctl_t ctl_sanitize(input logic [CTL_W-1:0] w);
    ctl_t c;
    c           = ctl_t'(w);
    c.fixed_one = 1'b1;
    c.rsvd      = '0;
    return c;
  endfunction
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl,
  input  logic sda,
  output logic start_det,
  output logic busy
);
  logic sda_d, scl_d, stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_d <= 1'b1;
      scl_d <= 1'b1;
    end else begin
      sda_d <= sda;
      scl_d <= scl;
    end
  end

  assign start_det = en & scl & scl_d & sda_d & ~sda;
  assign stop_det  = en & scl & scl_d & ~sda_d & sda;

  always_ff @(posedge clk) begin
    if (rst)            busy <= 1'b0;
    else if (!en)       busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end

  p_busy_start_r3: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);
  p_busy_stop_r4: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);
  p_busy_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy);
endmodule

// File: rtl/i2cmon_coll.sv
module i2cmon_coll #(
  parameter int BITS_PER_BYTE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic byte_mode,
  input  logic rxd_sample,
  input  logic auto_clr,
  input  logic xfer_clk,
  input  logic rxd,
  input  logic tx_bit,
  input  logic sda,
  input  logic start_det,
  input  logic arb_clr,
  output logic arb_lost,
  output logic coll_pulse,
  output logic te_clr
);
  localparam int CW = (BITS_PER_BYTE > 1) ? $clog2(BITS_PER_BYTE) : 1;
  localparam logic [CW-1:0] LAST = CW'(BITS_PER_BYTE - 1);

  logic          xfer_d, rxd_d;
  logic          samp, coll_now, last_bit, byte_done, arb_set, acc;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_d <= 1'b0;
      rxd_d  <= 1'b1;
    end else begin
      xfer_d <= xfer_clk;
      rxd_d  <= rxd;
    end
  end

  assign samp      = en & (rxd_sample ? (rxd_d & ~rxd) : (xfer_clk & ~xfer_d));
  assign coll_now  = samp & tx_bit & ~sda;
  assign last_bit  = (cnt == LAST);
  assign byte_done = samp & byte_mode & last_bit;
  assign arb_set   = byte_mode ? (byte_done & (acc | coll_now)) : coll_now;

  always_ff @(posedge clk) begin
    if (rst || !en || start_det) begin
      cnt <= '0;
      acc <= 1'b0;
    end else if (samp) begin
      if (last_bit) begin
        cnt <= '0;
        acc <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        acc <= acc | coll_now;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arb_lost   <= 1'b0;
      coll_pulse <= 1'b0;
      te_clr     <= 1'b0;
    end else begin
      if (arb_set)      arb_lost <= 1'b1;
      else if (arb_clr) arb_lost <= 1'b0;
      coll_pulse <= coll_now;
      te_clr     <= coll_now & auto_clr;
    end
  end

  p_coll_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (samp && tx_bit && !sda) |=> coll_pulse);
  p_byte_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (byte_mode && !byte_done && !arb_clr) |=> $stable(arb_lost));
  p_teclr_on_r9: assert property (@(posedge clk) disable iff (rst)
    (coll_now && auto_clr) |=> te_clr);
  p_teclr_off_r9: assert property (@(posedge clk) disable iff (rst)
    !auto_clr |=> !te_clr);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    arb_set |=> arb_lost);
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (arb_clr && !arb_set) |=> !arb_lost);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int BITS_PER_BYTE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wd,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             scl_pin,
  input  logic             sda_pin,
  input  logic             tx_bit,
  input  logic             xfer_clk,
  input  logic             rxd,
  input  logic             timer_uf,
  input  logic             arb_clr,
  output logic             busy,
  output logic             arb_lost,
  output logic             coll_pulse,
  output logic             te_clr,
  output logic             tx_start
);
  ctl_t       ctl;
  logic [1:0] pins_s;
  logic       start_det, xclk_d, xrise;

  always_ff @(posedge clk) begin
    if (rst)         ctl <= ctl_t'(CTL_RESET);
    else if (ctl_we) ctl <= ctl_sanitize(ctl_wd);
  end
  assign ctl_q = ctl;

  i2cmon_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk), .rst (rst), .d ({scl_pin, sda_pin}), .q (pins_s)
  );

  i2cmon_cond u_cond (
    .clk (clk), .rst (rst), .en (ctl.i2c_en),
    .scl (pins_s[1]), .sda (pins_s[0]),
    .start_det (start_det), .busy (busy)
  );

  i2cmon_coll #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_coll (
    .clk (clk), .rst (rst), .en (ctl.i2c_en), .byte_mode (ctl.byte_mode),
    .rxd_sample (ctl.rxd_sample), .auto_clr (ctl.auto_clr),
    .xfer_clk (xfer_clk), .rxd (rxd), .tx_bit (tx_bit), .sda (pins_s[0]),
    .start_det (start_det), .arb_clr (arb_clr),
    .arb_lost (arb_lost), .coll_pulse (coll_pulse), .te_clr (te_clr)
  );

  assign xrise = xfer_clk & ~xclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      xclk_d   <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      xclk_d   <= xfer_clk;
      tx_start <= ctl.timer_start ? timer_uf : xrise;
    end
  end

  p_tx_timer_r11: assert property (@(posedge clk) disable iff (rst)
    (ctl.timer_start && timer_uf) |=> tx_start);
  p_tx_xclk_r11: assert property (@(posedge clk) disable iff (rst)
    (!ctl.timer_start && xrise) |=> tx_start);
  p_ctl_fixed_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (ctl_q[7] && ctl_q[6:5] == 2'b00));
endmodule

// File: tb/i2c_bus_monitor_tb_top.sv
module i2c_bus_monitor_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wd = 8'h00;
  logic [7:0] ctl_q;
  logic scl_pin = 1'b1, sda_pin = 1'b1, tx_bit = 1'b0, xfer_clk = 1'b0;
  logic rxd = 1'b1, timer_uf = 1'b0, arb_clr = 1'b0;
  logic busy, arb_lost, coll_pulse, te_clr, tx_start;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  i2c_bus_monitor dut_i (
    .clk (clk), .rst (rst), .ctl_we (ctl_we), .ctl_wd (ctl_wd), .ctl_q (ctl_q),
    .scl_pin (scl_pin), .sda_pin (sda_pin), .tx_bit (tx_bit), .xfer_clk (xfer_clk),
    .rxd (rxd), .timer_uf (timer_uf), .arb_clr (arb_clr), .busy (busy),
    .arb_lost (arb_lost), .coll_pulse (coll_pulse), .te_clr (te_clr), .tx_start (tx_start)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl_expect(input logic [7:0] w);
    return {1'b1, 2'b00, w[4:0]};
  endfunction

  function automatic logic arb_next(input logic prev, input logic bmode,
                                    input int idx, input logic acc, input logic coll);
    if (!bmode) return prev | coll;
    if (idx == 7) return prev | acc | coll;
    return prev;
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wd = v; ctl_we = 1'b1;
    step(1);
    ctl_we = 1'b0;
  endtask

  task automatic do_start();
    scl_pin = 1'b1; sda_pin = 1'b1; step(4);
    sda_pin = 1'b0; step(4);
    scl_pin = 1'b0; step(4);
  endtask

  task automatic do_stop();
    sda_pin = 1'b0; step(4);
    scl_pin = 1'b1; step(4);
    sda_pin = 1'b1; step(4);
  endtask

  task automatic clear_arb();
    arb_clr = 1'b1; step(1); arb_clr = 1'b0;
  endtask

  // one sampling point on xfer_clk; returns outputs seen right after the sampling edge
  task automatic xbit(input logic t, input logic s, output logic a, output logic c, output logic e);
    tx_bit = t; sda_pin = s; step(4);
    xfer_clk = 1'b1; step(1);
    a = arb_lost; c = coll_pulse; e = te_clr;
    xfer_clk = 1'b0; step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a, c, e;
    logic exp_arb, acc, bmode, coll;
    logic [7:0] w;
    void'($urandom(32'd2024));
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 ctl_q", ctl_q, 8'h80);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 arb_lost", {7'd0, arb_lost}, 8'd0);
    chk("R1 te_clr/coll/tx_start", {5'd0, te_clr, coll_pulse, tx_start}, 8'd0);

    // R2 control write, fixed bits
    wr_ctl(8'h7F);
    chk("R2 write 7F", ctl_q, ctl_expect(8'h7F));
    for (int i = 0; i < 4; i++) begin
      w = 8'($urandom);
      wr_ctl(w);
      chk("R2 random write", ctl_q, ctl_expect(w));
    end

    // R5 disabled: no busy, no collision effects
    wr_ctl(8'h04);
    scl_pin = 1'b1; sda_pin = 1'b1; step(4);
    sda_pin = 1'b0; step(5);
    chk("R5 busy while disabled", {7'd0, busy}, 8'd0);
    scl_pin = 1'b0; step(2);
    xbit(1'b1, 1'b0, a, c, e);
    chk("R5 arb/coll/teclr while disabled", {5'd0, a, c, e}, 8'd0);

    // R3 START latency, R4 STOP
    wr_ctl(8'h01);
    scl_pin = 1'b1; sda_pin = 1'b1; step(4);
    sda_pin = 1'b0; step(2);
    chk("R3 busy not yet after 2 edges", {7'd0, busy}, 8'd0);
    step(1);
    chk("R3 busy after 3 edges", {7'd0, busy}, 8'd1);
    scl_pin = 1'b0; step(4);
    sda_pin = 1'b1; step(4); sda_pin = 1'b0; step(4);
    chk("R4 SDA toggles with SCL low keep busy", {7'd0, busy}, 8'd1);
    scl_pin = 1'b1; step(4);
    sda_pin = 1'b1; step(2);
    chk("R4 busy still set after 2 edges", {7'd0, busy}, 8'd1);
    step(1);
    chk("R4 busy cleared by STOP", {7'd0, busy}, 8'd0);
    scl_pin = 1'b0; step(2);
    sda_pin = 1'b0; step(4); sda_pin = 1'b1; step(4);
    chk("R4 no START while SCL low", {7'd0, busy}, 8'd0);

    // R6 per-bit, R9 auto-clear off
    xbit(1'b0, 1'b0, a, c, e);
    chk("R6 tx0 sda0 no collision", {5'd0, a, c, e}, 8'd0);
    xbit(1'b1, 1'b1, a, c, e);
    chk("R6 tx1 sda1 no collision", {5'd0, a, c, e}, 8'd0);
    xbit(1'b1, 1'b0, a, c, e);
    chk("R6 collision sets arb, R9 no teclr", {5'd0, a, c, e}, 8'b110);
    step(1);
    chk("R6 coll_pulse one cycle", {7'd0, coll_pulse}, 8'd0);

    // R10 clear, and set wins over clear
    clear_arb(); step(1);
    chk("R10 arb cleared", {7'd0, arb_lost}, 8'd0);
    tx_bit = 1'b1; sda_pin = 1'b0; step(4);
    xfer_clk = 1'b1; arb_clr = 1'b1; step(1);
    arb_clr = 1'b0; xfer_clk = 1'b0;
    chk("R10 collision beats clear", {7'd0, arb_lost}, 8'd1);
    step(1); clear_arb(); step(1);

    // R9 auto-clear on
    wr_ctl(8'h05);
    xbit(1'b1, 1'b0, a, c, e);
    chk("R9 teclr with collision", {5'd0, a, c, e}, 8'b111);
    step(1);
    chk("R9 teclr one cycle", {7'd0, te_clr}, 8'd0);
    clear_arb(); step(1);

    // R8 rxd falling sampling
    wr_ctl(8'h09);
    xbit(1'b1, 1'b0, a, c, e);
    chk("R8 xfer edge ignored", {5'd0, a, c, e}, 8'd0);
    rxd = 1'b0; step(1);
    chk("R8 rxd fall samples collision", {6'd0, arb_lost, coll_pulse}, 8'b11);
    rxd = 1'b1; step(2);
    clear_arb(); step(1);

    // R11 transmit start trigger
    wr_ctl(8'h00);
    timer_uf = 1'b1; step(1); timer_uf = 1'b0;
    chk("R11 timer ignored when not selected", {7'd0, tx_start}, 8'd0);
    xfer_clk = 1'b1; step(1); xfer_clk = 1'b0;
    chk("R11 xfer rise starts", {7'd0, tx_start}, 8'd1);
    step(1);
    wr_ctl(8'h10);
    xfer_clk = 1'b1; step(1); xfer_clk = 1'b0;
    chk("R11 xfer ignored when timer selected", {7'd0, tx_start}, 8'd0);
    timer_uf = 1'b1; step(1); timer_uf = 1'b0;
    chk("R11 timer starts", {7'd0, tx_start}, 8'd1);
    step(1);

    // R7 directed: single early collision in byte mode, flag waits for 8th bit
    wr_ctl(8'h03);
    do_start();
    for (int i = 0; i < 8; i++) begin
      xbit(1'b1, (i == 1) ? 1'b0 : 1'b1, a, c, e);
      if (i == 6) chk("R7 flag held before 8th bit", {7'd0, a}, 8'd0);
      if (i == 7) chk("R7 flag loads on 8th bit", {7'd0, a}, 8'd1);
    end
    do_stop(); clear_arb(); step(1);

    // R7 START restarts the bit count
    do_start();
    for (int i = 0; i < 5; i++) xbit(1'b0, 1'b1, a, c, e);
    scl_pin = 1'b0; sda_pin = 1'b1; step(4);
    do_start();
    for (int i = 0; i < 8; i++) begin
      xbit(1'b1, (i == 0) ? 1'b0 : 1'b1, a, c, e);
      if (i == 2) chk("R7 no load at old byte boundary", {7'd0, a}, 8'd0);
    end
    chk("R7 load at restarted 8th bit", {7'd0, a}, 8'd1);
    do_stop(); clear_arb(); step(1);

    // Random bytes, R6 and R7 against bench model
    for (int b = 0; b < 12; b++) begin
      bmode = 1'($urandom);
      wr_ctl({6'd0, bmode, 1'b1});
      clear_arb(); step(1);
      do_start();
      exp_arb = 1'b0; acc = 1'b0;
      for (int i = 0; i < 8; i++) begin
        logic t, s;
        t = 1'($urandom);
        s = ($urandom % 5 == 0) ? 1'b0 : t;
        coll = t & ~s;
        xbit(t, s, a, c, e);
        exp_arb = arb_next(exp_arb, bmode, i, acc, coll);
        acc = acc | coll;
        chk(bmode ? "R7 random byte arb" : "R6 random bit arb", {7'd0, a}, {7'd0, exp_arb});
        chk("R6 random coll_pulse", {7'd0, c}, {7'd0, coll});
      end
      do_stop();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule